// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Selectable Overflow Flag

This block is a purely combinational arithmetic unit of parameterized width. Its sum comes from a chain of one-bit full-adder cells, where each cell passes its carry to the next cell up. A two-bit operation code selects one of four operations: unsigned add, signed add, signed subtract, or two's complement negation of the second operand.

The same code also decides what the single overflow output means. In unsigned add it is the carry beyond the top bit. In signed add and signed subtract it is the two's complement range check. In negation it is raised when the operand is the most negative value, because that value has no positive counterpart.

Subtraction and negation share one path. That path inverts every bit of the second operand and feeds a carry-in of 1 into the lowest cell. Negation also forces the first operand to zero. The raw carry from the top cell is always visible, whatever the mode.

Top module: `addsub_ovf_unit`

## Requirements
- R1: With op_code 2'b00 (unsigned add), result equals (opnd_a + opnd_b) mod 2^W.
- R2: With op_code 2'b01 (signed add), result equals (opnd_a + opnd_b) mod 2^W. ovf_flag is 1 exactly when the true signed sum of the two's complement operands lies outside [-2^(W-1), 2^(W-1)-1].
- R3: With op_code 2'b01, ovf_flag is 0 whenever the top bits of opnd_a and opnd_b differ.
- R4: With op_code 2'b10 (signed subtract), result equals (opnd_a - opnd_b) mod 2^W. ovf_flag is 1 exactly when the true signed difference lies outside the signed W-bit range.
- R5: With op_code 2'b11 (negate), result equals (0 - opnd_b) mod 2^W, and opnd_a has no effect on any output. ovf_flag is 1 exactly when opnd_b is a 1 in bit W-1 with all other bits 0.
- R6: With op_code 2'b00, ovf_flag equals carry_out. This is 1 exactly when opnd_a + opnd_b >= 2^W.
- R7: carry_out is the raw carry from the top cell in every mode. In the add modes it is 1 when opnd_a + opnd_b >= 2^W. In subtract mode it is 1 when opnd_a >= opnd_b, compared as unsigned values. In negate mode it is 1 when opnd_b is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand; not used in negate mode |
| opnd_b | input | W | Second operand |
| op_code | input | 2 | Operation and overflow-meaning select |
| result | output | W | Low W bits of the selected operation |
| carry_out | output | 1 | Carry out of the top full-adder cell |
| ovf_flag | output | 1 | Overflow condition chosen by op_code |

## Verification
The bench builds two instances of the block.

The first uses the default width of 4. At that width every combination of both operands and all four codes can be applied (1024 vectors). This covers every sign pairing, the most negative operand and the carry boundary exactly.

The second uses width 9 and is driven with seeded random operands plus directed extremes. This shows that the parameterized chain, the most-negative-value detector and the sign-bit taps follow the width rather than a fixed position.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_UADD = 2'b00,
    OP_SADD = 2'b01,
    OP_SSUB = 2'b10,
    OP_NEG  = 2'b11
  } op_code_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_in,
  input  logic y_in,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);
  logic half;
  assign half  = x_in ^ y_in;
  assign s_out = half ^ c_in;
  assign c_out = (x_in & y_in) | (half & c_in);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_vec,
  input  logic [W-1:0] y_vec,
  input  logic         c_first,
  output logic [W-1:0] sum_vec,
  output logic         c_last,
  output logic         c_into_top
);
  logic [W:0] carry;
  assign carry[0] = c_first;

  for (genvar i = 0; i < W; i++) begin : g_cell
    fa_cell u_fa (
      .x_in (x_vec[i]),
      .y_in (y_vec[i]),
      .c_in (carry[i]),
      .s_out(sum_vec[i]),
      .c_out(carry[i+1])
    );
  end

  assign c_last     = carry[W];
  assign c_into_top = carry[W-1];
endmodule

// File: rtl/ovf_select.sv
module ovf_select
  import addsub_pkg::*;
(
  input  op_code_t op,
  input  logic     a_top,
  input  logic     b_top,
  input  logic     s_top,
  input  logic     c_last,
  input  logic     b_is_min,
  output logic     ovf
);
  always_comb begin
    unique case (op)
      OP_UADD: ovf = c_last;
      OP_SADD: ovf = ~(a_top ^ b_top) & (b_top ^ s_top);
      OP_SSUB: ovf = (a_top ^ b_top) & (s_top ^ a_top);
      OP_NEG:  ovf = b_is_min;
      default: ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_ovf_unit.sv
module addsub_ovf_unit
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   op_code,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf_flag
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  op_code_t     op;
  logic         invert_b;
  logic         zero_a;
  logic [W-1:0] x_cond;
  logic [W-1:0] y_cond;
  logic [W-1:0] sum_w;
  logic         c_top;
  logic         c_pre_top;
  logic         b_min;

  assign op       = op_code_t'(op_code);
  assign invert_b = op_code[1];
  assign zero_a   = (op == OP_NEG);
  assign x_cond   = zero_a ? '0 : opnd_a;
  assign y_cond   = invert_b ? ~opnd_b : opnd_b;
  assign b_min    = (opnd_b == MIN_NEG);

  ripple_chain #(.W(W)) u_chain (
    .x_vec     (x_cond),
    .y_vec     (y_cond),
    .c_first   (invert_b),
    .sum_vec   (sum_w),
    .c_last    (c_top),
    .c_into_top(c_pre_top)
  );

  logic unused_pre_top;
  assign unused_pre_top = c_pre_top;

  ovf_select u_ovf (
    .op      (op),
    .a_top   (opnd_a[MSB]),
    .b_top   (opnd_b[MSB]),
    .s_top   (sum_w[MSB]),
    .c_last  (c_top),
    .b_is_min(b_min),
    .ovf     (ovf_flag)
  );

  assign result    = sum_w;
  assign carry_out = c_top;
endmodule

// File: rtl/addsub_ovf_chk.sv
module addsub_ovf_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [1:0]   op_code,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf_flag
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] add_w;
  logic [W-1:0] sub_w;
  assign add_w = opnd_a + opnd_b;
  assign sub_w = opnd_a - opnd_b;

  always_comb begin
    if (op_code == 2'b00) begin
      a_r1_uadd_sum: assert (result == add_w);
      a_r6_uadd_ovf_is_carry: assert (ovf_flag == carry_out);
    end
    if (op_code == 2'b01) begin
      a_r2_sadd_sum: assert (result == add_w);
      if (opnd_a[W-1] != opnd_b[W-1]) begin
        a_r3_no_overflow: assert (!ovf_flag);
      end
    end
    if (op_code == 2'b10) begin
      a_r4_ssub_diff: assert (result == sub_w);
      a_r7_sub_carry: assert (carry_out == (opnd_a >= opnd_b));
    end
    if (op_code == 2'b11) begin
      a_r5_neg_ovf_min: assert (ovf_flag == (opnd_b == MIN_NEG));
      a_r7_neg_carry: assert (carry_out == (opnd_b == '0));
    end
  end
endmodule

bind addsub_ovf_unit addsub_ovf_chk #(.W(W)) u_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .op_code  (op_code),
  .result   (result),
  .carry_out(carry_out),
  .ovf_flag (ovf_flag)
);

// File: tb/tb_addsub_ovf_unit.sv
module tb_addsub_ovf_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 4;
  localparam int WB = 9;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WA-1:0] a4, b4, r4;
  logic [1:0]    m4;
  logic          c4, v4;
  logic [WB-1:0] a9, b9, r9;
  logic [1:0]    m9;
  logic          c9, v9;

  addsub_ovf_unit #(.W(WA)) dut (
    .opnd_a(a4), .opnd_b(b4), .op_code(m4),
    .result(r4), .carry_out(c4), .ovf_flag(v4)
  );
  addsub_ovf_unit #(.W(WB)) dut_w (
    .opnd_a(a9), .opnd_b(b9), .op_code(m9),
    .result(r9), .carry_out(c9), .ovf_flag(v9)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Interpret the low w bits of v as a two's complement value.
  function automatic longint as_signed(input longint v, input int w);
    if (v >= (longint'(1) << (w - 1))) return v - (longint'(1) << w);
    return v;
  endfunction

  // Reference model built from the requirements with integer arithmetic.
  function automatic void model(input int w, input longint a, input longint b,
                                input int m, output longint res,
                                output bit co, output bit ov);
    longint lim, sa, sb, t;
    lim = longint'(1) << w;
    sa  = as_signed(a, w);
    sb  = as_signed(b, w);
    case (m)
      0, 1: begin
        res = (a + b) % lim;
        co  = (a + b) >= lim;
        if (m == 0) ov = co;
        else begin
          t  = sa + sb;
          ov = (t < -(lim / 2)) || (t > lim / 2 - 1);
        end
      end
      2: begin
        res = (a - b + lim) % lim;
        co  = (a >= b);
        t   = sa - sb;
        ov  = (t < -(lim / 2)) || (t > lim / 2 - 1);
      end
      default: begin
        res = (lim - b) % lim;
        co  = (b == 0);
        t   = -sb;
        ov  = (t > lim / 2 - 1);
      end
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run4(input int a, input int b, input int m);
    longint er; bit ec, ev;
    a4 = WA'(a); b4 = WA'(b); m4 = 2'(m);
    #(CLK_PERIOD/2);
    model(WA, longint'(a), longint'(b), m, er, ec, ev);
    cmp(tag_of(m), "result", longint'(r4), er);
    cmp("R7", "carry_out", longint'(c4), longint'(ec));
    cmp(m == 0 ? "R6" : tag_of(m), "ovf_flag", longint'(v4), longint'(ev));
  endtask

  task automatic run9(input int a, input int b, input int m);
    longint er; bit ec, ev;
    a9 = WB'(a); b9 = WB'(b); m9 = 2'(m);
    #(CLK_PERIOD/2);
    model(WB, longint'(a), longint'(b), m, er, ec, ev);
    cmp(tag_of(m), "result9", longint'(r9), er);
    cmp("R7", "carry_out9", longint'(c9), longint'(ec));
    cmp(m == 0 ? "R6" : tag_of(m), "ovf_flag9", longint'(v9), longint'(ev));
  endtask

  initial begin
    int seed_dummy;
    a4 = '0; b4 = '0; m4 = '0;
    a9 = '0; b9 = '0; m9 = '0;
    seed_dummy = $urandom(32'd1234);
    #(CLK_PERIOD/2);
    // Idle state: zero inputs, unsigned add -> all outputs zero (R1)
    cmp("R1", "idle result", longint'(r4), 0);
    cmp("R6", "idle ovf", longint'(v4), 0);

    // Exhaustive sweep at the default width
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(a, b, m);

    // R3: opposite-sign signed add never flags overflow
    run4(7, 8, 1);
    cmp("R3", "opp-sign ovf", longint'(v4), 0);
    run4(8, 7, 1);
    cmp("R3", "opp-sign ovf rev", longint'(v4), 0);

    // R5: negate ignores a; compare outputs under differing a
    begin
      logic [WA-1:0] r_ref; logic c_ref, v_ref;
      run4(0, 5, 3);
      r_ref = r4; c_ref = c4; v_ref = v4;
      for (int a = 1; a < 16; a++) begin
        run4(a, 5, 3);
        cmp("R5", "a ignored result", longint'(r4), longint'(r_ref));
        cmp("R5", "a ignored carry", longint'(c4), longint'(c_ref));
        cmp("R5", "a ignored ovf", longint'(v4), longint'(v_ref));
      end
    end
    run4(3, 8, 3);
    cmp("R5", "negate min ovf", longint'(v4), 1);

    // Wider instance: directed extremes
    run9(255, 256, 3);
    run9(0, 256, 3);
    run9(511, 1, 0);
    run9(255, 1, 1);
    run9(256, 1, 2);
    run9(255, 511, 2);
    run9(0, 0, 3);
    // Wider instance: seeded random
    for (int i = 0; i < 2000; i++)
      run9(int'($urandom_range(511)), int'($urandom_range(511)),
           int'($urandom_range(3)));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule